// File: doc/BRIEF.md
# Quad SPI Flash Transaction Engine

This block carries out a single serial-flash transaction for each request it accepts. A requester presents an opcode, a 32-bit address, a byte count and the current read latency setting. The engine then drives the flash select, the serial clock and four data lines, each with its own output enable. It shifts the opcode, shifts the address, inserts idle latency cycles where the command needs them, and then moves data bytes. Program data comes from the requester over a valid/ready stream, and read data goes back over a second valid/ready stream.

The engine picks the lane count separately for each phase, based on the command class. The opcode always travels on IO0 alone. The address goes out on one lane or on four. The data phase uses one lane or four. A 1-lane read samples IO1. On reads, the engine releases the data lines as soon as the address is out, so the flash can take over the bus. The controller uses clock mode 0 with SCK idle low. It launches outgoing bits while SCK is low and captures incoming bits on the SCK rising edge. The engine runs one SCK period per two system clocks. It pauses SCK, held low, whenever a program byte has not yet arrived or the read output is still full.

Top module: `qspi_xact_engine`

## Requirements
- R1: Every accepted transaction starts with 8 SCK cycles that carry the opcode MSB first on IO0, with io_oe = 4'b0001 in each of them.
- R2: Opcodes 13h, 21h, 12h, 34h and ECh send all 32 address bits. Opcodes 03h, 20h, 02h, 32h and 38h send only address bits 23:0. In both cases the address goes MSB first.
- R3: Opcodes ECh and 38h send the address on four lanes with io_oe = 4'hF, one nibble per SCK with IO3 as the nibble's MSB. All other opcodes send the address on IO0 with io_oe = 4'b0001.
- R4: Data uses four lanes (nibble per SCK, high nibble first, IO3 = MSB) for ECh, 32h, 34h and 38h. For 03h, 13h, 02h and 12h, data uses one lane: program bits go out on IO0 and read bits are sampled from IO1.
- R5: Opcode ECh inserts exactly dummy_cycles SCK cycles between address and data, with io_oe = 0. Opcodes 03h and 13h go directly from address to data.
- R6: On read opcodes, io_oe is 0 from the first SCK cycle after the last address cycle until the end of the transaction.
- R7: Erase opcodes 20h and 21h have no data phase. spi_cs_n rises at the end of the last address SCK cycle, giving exactly 8 + 24 or 8 + 32 SCK cycles.
- R8: Program opcodes move min(req_len, 256) bytes. Read opcodes return req_len bytes. A count of zero ends the transaction after the address.
- R9: Each read byte is presented once on rd_data/rd_valid. While rd_valid is high and rd_ready is low, rd_data stays stable, and no further byte is lost.
- R10: Program bytes are taken one per wr_valid/wr_ready handshake. SCK does not advance into a program byte that has not been received.
- R11: SCK is low whenever spi_cs_n is high. Bits change only while SCK is low.
- R12: An opcode outside the supported set is accepted and completed with a one-cycle xact_done pulse, without asserting spi_cs_n or toggling SCK. xact_done never stays high for two cycles in a row.
- R13: After reset: spi_cs_n = 1, spi_sck = 0, io_oe = 0, rd_valid = 0, xact_done = 0, req_ready = 1. io_oe is 0 whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_opcode | input | 8 | Command byte |
| req_addr | input | 32 | Flash byte address |
| req_len | input | LEN_W (16) | Data byte count |
| dummy_cycles | input | DUMMY_W (5) | Read latency in SCK cycles |
| wr_data | input | 8 | Program byte |
| wr_valid | input | 1 | Program byte present |
| wr_ready | output | 1 | Engine takes program byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Requester takes read byte |
| xact_done | output | 1 | One-cycle pulse at transaction end |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash select, active low |
| io_out | output | 4 | Data line drive values |
| io_oe | output | 4 | Per-lane output enables |
| io_in | input | 4 | Data line receive values |

## Verification
The hardest situation to create from the ports is a read byte finishing while the previous byte still sits unaccepted. This stalls SCK in the middle of a quad read that follows a latency phase. The bench throttles rd_ready to one cycle in seven during long reads, so the last slot of each byte collides with a held output. Program transfers get the matching treatment: wr_valid drops at regular gaps, and a 300-byte request reaches the 256-byte cap. A flash model in the bench decodes each transaction from the bus. It drives read data on the lane the command class implies and the inverse value on the other lanes, so sampling the wrong lane corrupts the returned bytes.

// File: rtl/qspi_xact_pkg.sv
package qspi_xact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_WDATA, ST_RDATA, ST_DONE
  } phase_e;

  // Per-command phase shape
  typedef struct packed {
    logic wide_addr;   // 32 address bits instead of 24
    logic addr_x4;     // address on four lanes
    logic uses_dummy;  // latency cycles before read data
    logic rd;          // data flows from flash
    logic wr;          // data flows to flash
    logic data_x4;     // data on four lanes
  } op_class_t;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      8'h03, 8'h13, 8'hEC, 8'h20, 8'h21,
      8'h02, 8'h12, 8'h32, 8'h34, 8'h38: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic op_class_t op_shape(input logic [7:0] op);
    op_class_t c;
    c = '0;
    case (op)
      8'h03: c.rd = 1'b1;
      8'h13: begin c.rd = 1'b1; c.wide_addr = 1'b1; end
      8'hEC: begin
        c.rd = 1'b1; c.wide_addr = 1'b1; c.addr_x4 = 1'b1;
        c.data_x4 = 1'b1; c.uses_dummy = 1'b1;
      end
      8'h21: c.wide_addr = 1'b1;
      8'h02: c.wr = 1'b1;
      8'h12: begin c.wr = 1'b1; c.wide_addr = 1'b1; end
      8'h32: begin c.wr = 1'b1; c.data_x4 = 1'b1; end
      8'h34: begin c.wr = 1'b1; c.wide_addr = 1'b1; c.data_x4 = 1'b1; end
      8'h38: begin c.wr = 1'b1; c.addr_x4 = 1'b1; c.data_x4 = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/qspi_op_decode.sv
module qspi_op_decode
  import qspi_xact_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       known,
  output op_class_t  shape
);
  assign known = op_known(opcode);
  assign shape = op_shape(opcode);
endmodule

// File: rtl/qspi_tx_lanes.sv
module qspi_tx_lanes #(
  parameter int SH_W = 32
) (
  input  logic [SH_W-1:0] sh,
  input  logic            x4,
  output logic [3:0]      lanes
);
  generate
    if (SH_W >= 4) begin : g_mux
      assign lanes = x4 ? sh[SH_W-1 -: 4] : {3'b000, sh[SH_W-1]};
    end else begin : g_narrow
      assign lanes = {3'b000, sh[SH_W-1]};
    end
  endgenerate
endmodule

// File: rtl/qspi_rx_gather.sv
module qspi_rx_gather #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              x4,
  input  logic [3:0]        io_in,
  output logic [BYTE_W-1:0] acc_next
);
  logic [BYTE_W-1:0] acc;

  // single-lane reads take the flash's serial output line (IO1)
  assign acc_next = x4 ? {acc[BYTE_W-5:0], io_in} : {acc[BYTE_W-2:0], io_in[1]};

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (strobe) acc <= acc_next;
  end
endmodule

// File: rtl/qspi_xact_engine.sv
module qspi_xact_engine
  import qspi_xact_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int DUMMY_W    = 5,
  parameter int PAGE_BYTES = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_opcode,
  input  logic [31:0]        req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DUMMY_W-1:0] dummy_cycles,
  input  logic [7:0]         wr_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic               xact_done,
  output logic               spi_sck,
  output logic               spi_cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in
);
  localparam int SLOT_W = (DUMMY_W > 6) ? DUMMY_W : 6;
  localparam int SH_W   = 32;
  localparam logic [LEN_W-1:0] PAGE_CAP = LEN_W'(PAGE_BYTES);
  localparam logic [3:0] OE_ONE  = 4'b0001;
  localparam logic [3:0] OE_FOUR = 4'b1111;

  phase_e             st;
  logic               half;
  logic [SLOT_W-1:0]  slots;
  logic [SH_W-1:0]    tx_sh;
  logic               x4;
  logic [2:0]         bslot;
  logic               loaded;
  logic [LEN_W-1:0]   bytes_left;
  op_class_t          cls_q;
  logic [31:0]        addr_q;
  logic [DUMMY_W-1:0] dummy_q;
  logic               sck_q, cs_q, rdv_q, done_q;
  logic [3:0]         oe_q;
  logic [7:0]         rdd_q;

  logic       in_known;
  op_class_t  in_shape;
  logic [7:0] rx_next;
  logic       byte_last, rd_hold, rise, rx_strobe;
  phase_e     after_addr, after_dummy, tgt;
  logic [SH_W-1:0] tx_shifted;

  qspi_op_decode u_dec (
    .opcode (req_opcode),
    .known  (in_known),
    .shape  (in_shape)
  );

  qspi_tx_lanes #(.SH_W(SH_W)) u_tx (
    .sh    (tx_sh),
    .x4    (x4),
    .lanes (io_out)
  );

  qspi_rx_gather #(.BYTE_W(8)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .strobe   (rx_strobe),
    .x4       (x4),
    .io_in    (io_in),
    .acc_next (rx_next)
  );

  assign req_ready = (st == ST_IDLE) && !rdv_q;
  assign wr_ready  = (st == ST_WDATA) && !half && !loaded;
  assign byte_last = x4 ? (bslot == 3'd1) : (bslot == 3'd7);
  assign rd_hold   = rdv_q && !rd_ready && byte_last;
  assign tx_shifted = x4 ? (tx_sh << 4) : (tx_sh << 1);

  always_comb begin
    rise = 1'b0;
    if (!half) begin
      case (st)
        ST_CMD, ST_ADDR, ST_DUMMY: rise = 1'b1;
        ST_WDATA:                  rise = loaded;
        ST_RDATA:                  rise = !rd_hold;
        default:                   rise = 1'b0;
      endcase
    end
  end
  assign rx_strobe = rise && (st == ST_RDATA);

  always_comb begin
    if (cls_q.rd) begin
      if (cls_q.uses_dummy && dummy_q != '0) after_addr = ST_DUMMY;
      else if (bytes_left != '0)             after_addr = ST_RDATA;
      else                                   after_addr = ST_DONE;
    end else if (cls_q.wr && bytes_left != '0) begin
      after_addr = ST_WDATA;
    end else begin
      after_addr = ST_DONE;
    end
    after_dummy = (bytes_left != '0) ? ST_RDATA : ST_DONE;
    tgt = (st == ST_ADDR) ? after_addr : after_dummy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; half <= 1'b0; slots <= '0; tx_sh <= '0; x4 <= 1'b0;
      bslot <= '0; loaded <= 1'b0; bytes_left <= '0; cls_q <= '0;
      addr_q <= '0; dummy_q <= '0; sck_q <= 1'b0; cs_q <= 1'b1;
      oe_q <= '0; rdv_q <= 1'b0; rdd_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      if (rx_strobe && byte_last) begin
        rdv_q <= 1'b1;
        rdd_q <= rx_next;
      end

      if (rise) begin
        sck_q <= 1'b1;
        half  <= 1'b1;
      end

      case (st)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            cls_q   <= in_shape;
            addr_q  <= req_addr;
            dummy_q <= dummy_cycles;
            if (in_shape.rd)      bytes_left <= req_len;
            else if (in_shape.wr) bytes_left <= (req_len > PAGE_CAP) ? PAGE_CAP : req_len;
            else                  bytes_left <= '0;
            if (in_known) begin
              st    <= ST_CMD;
              cs_q  <= 1'b0;
              tx_sh <= {req_opcode, 24'h000000};
              x4    <= 1'b0;
              oe_q  <= OE_ONE;
              slots <= SLOT_W'(8);
              half  <= 1'b0;
            end else begin
              st <= ST_DONE;
            end
          end
        end

        ST_CMD: begin
          if (half) begin
            sck_q <= 1'b0;
            half  <= 1'b0;
            if (slots != SLOT_W'(1)) begin
              slots <= slots - 1'b1;
              tx_sh <= tx_shifted;
            end else begin
              st    <= ST_ADDR;
              tx_sh <= cls_q.wide_addr ? addr_q : {addr_q[23:0], 8'h00};
              x4    <= cls_q.addr_x4;
              oe_q  <= cls_q.addr_x4 ? OE_FOUR : OE_ONE;
              slots <= SLOT_W'(cls_q.wide_addr ? (cls_q.addr_x4 ? 8 : 32)
                                               : (cls_q.addr_x4 ? 6 : 24));
            end
          end
        end

        ST_ADDR, ST_DUMMY: begin
          if (half) begin
            sck_q <= 1'b0;
            half  <= 1'b0;
            if (slots != SLOT_W'(1)) begin
              slots <= slots - 1'b1;
              tx_sh <= tx_shifted;
            end else begin
              st <= tgt;
              case (tgt)
                ST_DUMMY: begin
                  oe_q  <= '0;
                  slots <= SLOT_W'(dummy_q);
                end
                ST_RDATA: begin
                  oe_q  <= '0;
                  bslot <= '0;
                  x4    <= cls_q.data_x4;
                end
                ST_WDATA: begin
                  oe_q   <= cls_q.data_x4 ? OE_FOUR : OE_ONE;
                  x4     <= cls_q.data_x4;
                  bslot  <= '0;
                  loaded <= 1'b0;
                end
                default: begin
                  cs_q <= 1'b1;
                  oe_q <= '0;
                end
              endcase
            end
          end
        end

        ST_WDATA, ST_RDATA: begin
          if (st == ST_WDATA && !half && !loaded && wr_valid) begin
            tx_sh  <= {wr_data, 24'h000000};
            loaded <= 1'b1;
          end
          if (half) begin
            sck_q <= 1'b0;
            half  <= 1'b0;
            if (byte_last) begin
              bslot      <= '0;
              loaded     <= 1'b0;
              bytes_left <= bytes_left - 1'b1;
              if (bytes_left == LEN_W'(1)) begin
                st   <= ST_DONE;
                cs_q <= 1'b1;
                oe_q <= '0;
              end
            end else begin
              bslot <= bslot + 1'b1;
              tx_sh <= tx_shifted;
            end
          end
        end

        ST_DONE: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

  assign spi_sck   = sck_q;
  assign spi_cs_n  = cs_q;
  assign io_oe     = oe_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
  assign xact_done = done_q;

endmodule

// File: rtl/qspi_xact_engine_chk.sv
module qspi_xact_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic [3:0] io_oe,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       req_ready,
  input logic       xact_done
);
  p_sck_low_deselect_r11: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  p_oe_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));

  p_oe_off_deselect_r13: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (io_oe == 4'b0000));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    xact_done |=> !xact_done);

  p_accept_idle_r13: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);
endmodule

bind qspi_xact_engine qspi_xact_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .io_oe     (io_oe),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .req_ready (req_ready),
  .xact_done (xact_done)
);

// File: tb/tb_qspi_xact_engine.sv
module tb_qspi_xact_engine;
  localparam int LEN_W = 16;
  localparam int DUMMY_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [7:0]         req_opcode = '0;
  logic [31:0]        req_addr = '0;
  logic [LEN_W-1:0]   req_len = '0;
  logic [DUMMY_W-1:0] dummy_cycles = '0;
  logic [7:0]         wr_data = '0;
  logic               wr_valid = 1'b0;
  logic               wr_ready;
  logic [7:0]         rd_data;
  logic               rd_valid;
  logic               rd_ready = 1'b1;
  logic               xact_done;
  logic               spi_sck, spi_cs_n;
  logic [3:0]         io_out, io_oe;
  logic [3:0]         io_in = 4'h0;

  qspi_xact_engine #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W), .PAGE_BYTES(256)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_len(req_len),
    .dummy_cycles(dummy_cycles), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .xact_done(xact_done), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {known, wide_addr, addr_x4, dummy, read, write, data_x4}
  function automatic logic [6:0] bclass(input logic [7:0] op);
    case (op)
      8'h03: return 7'b1000100;
      8'h13: return 7'b1100100;
      8'hEC: return 7'b1111101;
      8'h20: return 7'b1000000;
      8'h21: return 7'b1100000;
      8'h02: return 7'b1000010;
      8'h12: return 7'b1100010;
      8'h32: return 7'b1000011;
      8'h34: return 7'b1100011;
      8'h38: return 7'b1010011;
      default: return 7'b0000000;
    endcase
  endfunction

  logic [7:0]  cur_op = '0;
  logic [31:0] cur_addr = '0;
  int          cur_dummy = 0;
  bit          stall_rd = 0;

  function automatic logic [7:0] rpat(input int k);
    return 8'(k * 29 + 60) ^ cur_addr[7:0];
  endfunction
  function automatic logic [7:0] wpat(input int k);
    return 8'(k * 13 + 165);
  endfunction

  logic [3:0] rec_out[$];
  logic [3:0] rec_oe[$];
  logic [7:0] rd_q[$];
  int wr_idx = 0;
  bit cs_seen_low = 0;
  int cyc = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  bit hold_pend = 0;
  logic [7:0] hold_val = '0;

  // flash model and per-clock checks, away from the active edge
  logic [6:0] m_cls;
  int m_n, m_ds, m_bps, m_k, m_p;
  logic [7:0] m_b;
  logic m_bit;
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_sck && !prev_sck) begin
        rec_out.push_back(io_out);
        rec_oe.push_back(io_oe);
      end
      if (!spi_cs_n) cs_seen_low = 1;
      if ((!spi_sck && prev_sck) || (!spi_cs_n && prev_cs)) begin
        m_cls = bclass(cur_op);
        m_n = rec_out.size();
        m_ds = 8 + ((m_cls[5] ? 32 : 24) / (m_cls[4] ? 4 : 1))
                 + ((m_cls[2] && m_cls[3]) ? cur_dummy : 0);
        if (m_cls[2] && m_n >= m_ds) begin
          m_bps = m_cls[0] ? 2 : 8;
          m_k = (m_n - m_ds) / m_bps;
          m_p = (m_n - m_ds) % m_bps;
          m_b = rpat(m_k);
          if (m_cls[0]) io_in = (m_p == 0) ? m_b[7:4] : m_b[3:0];
          else begin
            m_bit = m_b[7 - m_p];
            io_in = {~m_bit, ~m_bit, m_bit, ~m_bit};
          end
        end
      end
      chk(!(spi_cs_n && spi_sck), "R11", "sck high while deselected", 64'(spi_sck), 0);
      chk(!(spi_cs_n && io_oe != 4'h0), "R13", "lane driven while deselected", 64'(io_oe), 0);
      prev_sck = spi_sck;
      prev_cs = spi_cs_n;
    end
    wr_valid = (cyc % 5) != 2;
    wr_data  = wpat(wr_idx);
    rd_ready = stall_rd ? ((cyc % 7) == 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (wr_valid && wr_ready) wr_idx++;
      if (rd_valid && rd_ready) rd_q.push_back(rd_data);
      if (hold_pend)
        chk(rd_valid && rd_data == hold_val, "R9", "held read byte changed", 64'(rd_data), 64'(hold_val));
      hold_pend = rd_valid && !rd_ready;
      hold_val  = rd_data;
    end
  end

  task automatic analyze(input int len);
    logic [6:0] c;
    int nb, asl, dsl, bps, total, idx;
    bit ok, oeok;
    logic [31:0] got, exp_a;
    logic [7:0] v;
    c = bclass(cur_op);
    if (!c[6]) begin
      chk(!cs_seen_low, "R12", "select asserted for unknown opcode", 64'(cs_seen_low), 0);
      chk(rec_out.size() == 0, "R12", "sck cycles for unknown opcode", rec_out.size(), 0);
      return;
    end
    nb  = c[2] ? len : (c[1] ? ((len > 256) ? 256 : len) : 0);
    asl = (c[5] ? 32 : 24) / (c[4] ? 4 : 1);
    dsl = (c[2] && c[3]) ? cur_dummy : 0;
    bps = c[0] ? 2 : 8;
    total = 8 + asl + dsl + nb * bps;
    chk(rec_out.size() == total, (!c[2] && !c[1]) ? "R7" : "R8", "sck cycle count",
        rec_out.size(), total);
    if (rec_out.size() != total) return;
    ok = 1;
    for (int i = 0; i < 8; i++)
      if (rec_oe[i] != 4'b0001 || rec_out[i][0] != cur_op[7 - i]) ok = 0;
    chk(ok, "R1", "opcode on IO0", 64'(cur_op), 64'(cur_op));
    got = '0; oeok = 1;
    for (int j = 0; j < asl; j++) begin
      idx = 8 + j;
      if (c[4]) begin
        got = {got[27:0], rec_out[idx]};
        if (rec_oe[idx] != 4'hF) oeok = 0;
      end else begin
        got = {got[30:0], rec_out[idx][0]};
        if (rec_oe[idx] != 4'b0001) oeok = 0;
      end
    end
    exp_a = c[5] ? cur_addr : {8'h00, cur_addr[23:0]};
    chk(got == exp_a, "R2", "address bits", 64'(got), 64'(exp_a));
    chk(oeok, "R3", "address lane enables", 0, 1);
    ok = 1;
    for (int j = 0; j < dsl; j++) if (rec_oe[8 + asl + j] != 4'h0) ok = 0;
    if (c[3]) chk(ok, "R5", "latency cycles with lanes released", 0, 1);
    if (c[2]) begin
      ok = 1;
      for (int j = 8 + asl; j < total; j++) if (rec_oe[j] != 4'h0) ok = 0;
      chk(ok, "R6", "lanes released after address on read", 0, 1);
      chk(rd_q.size() == nb, "R8", "read byte count", rd_q.size(), nb);
      if (rd_q.size() == nb)
        for (int k = 0; k < nb; k++)
          chk(rd_q[k] == rpat(k), "R4", "read byte value", 64'(rd_q[k]), 64'(rpat(k)));
    end
    if (c[1]) begin
      chk(wr_idx == nb, "R10", "program bytes taken", wr_idx, nb);
      ok = 1; oeok = 1;
      for (int k = 0; k < nb; k++) begin
        v = '0;
        for (int p = 0; p < bps; p++) begin
          idx = 8 + asl + k * bps + p;
          v = c[0] ? {v[3:0], rec_out[idx]} : {v[6:0], rec_out[idx][0]};
          if (rec_oe[idx] != (c[0] ? 4'hF : 4'h1)) oeok = 0;
        end
        if (v != wpat(k)) begin
          ok = 0;
          $display("FAIL R4 program byte %0d: actual %0h expected %0h", k, v, wpat(k));
        end
      end
      chk(ok, "R4", "program data on bus", 0, 1);
      chk(oeok, "R4", "program lane enables", 0, 1);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [31:0] addr, input int len,
                     input int dmy, input bit stall);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rec_out.delete(); rec_oe.delete(); rd_q.delete();
    wr_idx = 0; cs_seen_low = 0;
    cur_op = op; cur_addr = addr; cur_dummy = dmy; stall_rd = stall;
    req_valid = 1'b1; req_opcode = op; req_addr = addr;
    req_len = LEN_W'(len); dummy_cycles = DUMMY_W'(dmy);
    @(negedge clk);
    req_valid = 1'b0;
    while (!xact_done) @(negedge clk);
    chk(1'b1, "R12", "done pulse seen", 1, 1);
    while (rd_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    analyze(len);
    stall_rd = 0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R13", "reset cs_n", 64'(spi_cs_n), 1);
    chk(spi_sck == 1'b0, "R13", "reset sck", 64'(spi_sck), 0);
    chk(io_oe == 4'h0, "R13", "reset oe", 64'(io_oe), 0);
    chk(!rd_valid && !xact_done, "R13", "reset rd_valid/done", 64'({rd_valid, xact_done}), 0);
    chk(req_ready == 1'b1, "R13", "reset req_ready", 64'(req_ready), 1);
    rst = 1'b0;
    run(8'h03, 32'h00ABCDEF, 4, 0, 0);
    run(8'h13, 32'h12345678, 6, 0, 1);
    run(8'hEC, 32'h89ABCDEF, 5, 6, 0);
    run(8'hEC, 32'h0F1E2D3C, 9, 3, 1);
    run(8'hEC, 32'h55AA33CC, 2, 0, 0);
    run(8'h20, 32'h00123456, 0, 0, 0);
    run(8'h21, 32'hFEDCBA98, 7, 0, 0);
    run(8'h02, 32'h00010203, 5, 0, 0);
    run(8'h12, 32'hA1B2C3D4, 3, 0, 0);
    run(8'h32, 32'h00400080, 4, 0, 0);
    run(8'h34, 32'hC0FFEE00, 2, 0, 0);
    run(8'h38, 32'h00765432, 3, 0, 0);
    run(8'h02, 32'h00FF0000, 300, 0, 0);
    run(8'h03, 32'h00000100, 0, 0, 0);
    run(8'hAB, 32'h00000000, 4, 0, 0);
    run(8'h13, 32'h00000001, 3, 9, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule